// File: doc/BRIEF.md
# Two-Word Serial Code Lock

This block is a Moore state machine that guards a door-release signal with a two-word code. The code is keyed in on a narrow switch input. A one-cycle entry strobe captures the switch value on each attempt. When both words arrive correctly and in order, the unlock flag rises. When either word is wrong, the alarm flag rises, but only after the second attempt. Because a wrong first word is never flagged on its own, an observer cannot tell which of the two words failed.

Both flags stay set until a synchronous reset returns the machine to its idle state. The switch value is read only in cycles where the strobe is high. The strobe must already be a clean single-cycle pulse; debouncing the switches and shortening a button press into a pulse are left to the surrounding logic.

A parameter chooses how the five states are stored: either a three-bit binary register or a five-bit one-hot register. Both choices give the same behaviour at the ports. If the state register ever holds a code that belongs to no state, it falls back to idle on the next clock.

Top module: `code_lock_top`

## Requirements
- R1: While reset is high, and in the cycle after it is released with no strobe, both `open_o` and `error_o` are 0.
- R2: From idle, a strobe with `sw_i` equal to WORD_A (default 2'b01) moves to the first-correct state, and both outputs stay 0.
- R3: In a cycle where `enter_i` is 0 the state holds, whatever `sw_i` does. A change on `sw_i` then alters neither output nor the outcome of later entries.
- R4: After a correct first word, a strobe with `sw_i` equal to WORD_B (default 2'b11) sets `open_o` to 1 from the cycle after that clock edge. `error_o` stays 0.
- R5: A strobe from idle with any value other than WORD_A leaves both outputs at 0. The next strobe, with any switch value, sets `error_o` to 1.
- R6: After a correct first word, a strobe with any value other than WORD_B sets `error_o` to 1. `open_o` stays 0.
- R7: Once set, `open_o` and `error_o` hold through any further strobes and switch values until reset.
- R8: Reset is synchronous and active high. It returns the machine to idle from any state, and it wins over a strobe in the same cycle.
- R9: ONE_HOT=1 and ONE_HOT=0 produce identical outputs in every cycle for the same stimulus.
- R10: `open_o` and `error_o` are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset to idle |
| enter_i | input | 1 | One-cycle strobe that captures the switch value |
| sw_i | input | SW_W (2) | Code switch value |
| open_o | output | 1 | Unlock flag, registered |
| error_o | output | 1 | Alarm flag, registered |

## Verification
The assertions assume that `enter_i` is high for exactly one clock per attempt. They also assume that reset is applied at start-up before any strobe. Under those conditions the flags are sticky and a flag only rises on a strobe cycle.

The bench drives every input on the falling edge. It raises the strobe for one rising edge and then drops it. It always begins with a reset, so the state register is never observed holding an undefined value.

// File: rtl/code_lock_pkg.sv
package code_lock_pkg;

  localparam int unsigned N_STATES = 5;
  localparam int unsigned BIN_W    = 3;

  typedef enum logic [BIN_W-1:0] {
    LK_IDLE     = 3'b000,
    LK_PASS1    = 3'b001,
    LK_UNLOCKED = 3'b011,
    LK_MISS1    = 3'b100,
    LK_ALARM    = 3'b101
  } lock_state_e;

  // one-hot bit position of each state
  function automatic int unsigned oh_index(lock_state_e s);
    case (s)
      LK_IDLE:     return 0;
      LK_PASS1:    return 1;
      LK_UNLOCKED: return 2;
      LK_MISS1:    return 3;
      default:     return 4;
    endcase
  endfunction

endpackage

// File: rtl/lock_word_match.sv
module lock_word_match #(
  parameter int unsigned SW_W = 2,
  parameter logic [SW_W-1:0] WORD_A = 2'b01,
  parameter logic [SW_W-1:0] WORD_B = 2'b11
) (
  input  logic [SW_W-1:0] sw_i,
  output logic            hit_a_o,
  output logic            hit_b_o
);
  always_comb begin
    hit_a_o = (sw_i == WORD_A);
    hit_b_o = (sw_i == WORD_B);
  end
endmodule

// File: rtl/lock_next_state.sv
module lock_next_state
  import code_lock_pkg::*;
(
  input  lock_state_e cur_i,
  input  logic        cur_valid_i,
  input  logic        enter_i,
  input  logic        hit_a_i,
  input  logic        hit_b_i,
  output lock_state_e nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (!cur_valid_i) begin
      nxt_o = LK_IDLE;
    end else if (enter_i) begin
      case (cur_i)
        LK_IDLE:  nxt_o = hit_a_i ? LK_PASS1 : LK_MISS1;
        LK_PASS1: nxt_o = hit_b_i ? LK_UNLOCKED : LK_ALARM;
        LK_MISS1: nxt_o = LK_ALARM;
        default:  nxt_o = cur_i;
      endcase
    end
  end
endmodule

// File: rtl/lock_state_reg.sv
module lock_state_reg
  import code_lock_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic        clk,
  input  logic        rst,
  input  lock_state_e nxt_i,
  output lock_state_e cur_o,
  output logic        cur_valid_o
);
  localparam int unsigned REG_W = ONE_HOT ? N_STATES : BIN_W;

  logic [REG_W-1:0] st_q;

  if (ONE_HOT) begin : g_onehot
    logic [REG_W-1:0] nxt_vec;
    always_comb begin
      nxt_vec = '0;
      nxt_vec[oh_index(nxt_i)] = 1'b1;
    end
    always_ff @(posedge clk) begin
      if (rst) st_q <= REG_W'(1) << oh_index(LK_IDLE);
      else     st_q <= nxt_vec;
    end
    always_comb begin
      cur_valid_o = $onehot(st_q);
      cur_o = LK_IDLE;
      if (st_q[oh_index(LK_PASS1)])    cur_o = LK_PASS1;
      if (st_q[oh_index(LK_UNLOCKED)]) cur_o = LK_UNLOCKED;
      if (st_q[oh_index(LK_MISS1)])    cur_o = LK_MISS1;
      if (st_q[oh_index(LK_ALARM)])    cur_o = LK_ALARM;
    end
  end else begin : g_binary
    always_ff @(posedge clk) begin
      if (rst) st_q <= REG_W'(LK_IDLE);
      else     st_q <= REG_W'(nxt_i);
    end
    always_comb begin
      cur_o = lock_state_e'(st_q);
      cur_valid_o = (st_q == REG_W'(LK_IDLE))     || (st_q == REG_W'(LK_PASS1)) ||
                    (st_q == REG_W'(LK_UNLOCKED)) || (st_q == REG_W'(LK_MISS1)) ||
                    (st_q == REG_W'(LK_ALARM));
    end
  end

  // R9: whichever encoding is chosen, only legal codes appear after reset
  p_state_legal_r9: assert property (@(posedge clk) disable iff (rst) cur_valid_o)
    else $error("p_state_legal_r9: illegal state code");

endmodule

// File: rtl/lock_flag_reg.sv
module lock_flag_reg
  import code_lock_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  lock_state_e nxt_i,
  output logic        open_o,
  output logic        error_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      open_o  <= 1'b0;
      error_o <= 1'b0;
    end else begin
      open_o  <= (nxt_i == LK_UNLOCKED);
      error_o <= (nxt_i == LK_ALARM);
    end
  end

  p_open_sticky_r7: assert property (@(posedge clk) disable iff (rst) open_o |=> open_o)
    else $error("p_open_sticky_r7");
  p_error_sticky_r7: assert property (@(posedge clk) disable iff (rst) error_o |=> error_o)
    else $error("p_error_sticky_r7");
endmodule

// File: rtl/code_lock_top.sv
module code_lock_top
  import code_lock_pkg::*;
#(
  parameter int unsigned SW_W = 2,
  parameter logic [SW_W-1:0] WORD_A = 2'b01,
  parameter logic [SW_W-1:0] WORD_B = 2'b11,
  parameter bit ONE_HOT = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enter_i,
  input  logic [SW_W-1:0] sw_i,
  output logic            open_o,
  output logic            error_o
);
  logic        hit_a, hit_b, cur_valid;
  lock_state_e cur_st, nxt_st;

  lock_word_match #(.SW_W(SW_W), .WORD_A(WORD_A), .WORD_B(WORD_B)) u_match (
    .sw_i(sw_i), .hit_a_o(hit_a), .hit_b_o(hit_b)
  );

  lock_next_state u_next (
    .cur_i(cur_st), .cur_valid_i(cur_valid), .enter_i(enter_i),
    .hit_a_i(hit_a), .hit_b_i(hit_b), .nxt_o(nxt_st)
  );

  lock_state_reg #(.ONE_HOT(ONE_HOT)) u_state (
    .clk(clk), .rst(rst), .nxt_i(nxt_st), .cur_o(cur_st), .cur_valid_o(cur_valid)
  );

  lock_flag_reg u_flags (
    .clk(clk), .rst(rst), .nxt_i(nxt_st), .open_o(open_o), .error_o(error_o)
  );

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst) !(open_o && error_o))
    else $error("p_flags_exclusive_r10");
  p_reset_clears_r8: assert property (@(posedge clk) rst |=> (!open_o && !error_o))
    else $error("p_reset_clears_r8");
  p_idle_holds_r3: assert property (@(posedge clk) disable iff (rst)
                                    !enter_i |=> $stable({open_o, error_o}))
    else $error("p_idle_holds_r3");
  p_error_on_entry_r5: assert property (@(posedge clk) disable iff (rst)
                                        $rose(error_o) |-> $past(enter_i))
    else $error("p_error_on_entry_r5");
  p_open_on_entry_r4: assert property (@(posedge clk) disable iff (rst)
                                       $rose(open_o) |-> $past(enter_i))
    else $error("p_open_on_entry_r4");
endmodule

// File: tb/code_lock_top_tb_top.sv
module code_lock_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYC = 5000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enter = 1'b0;
  logic [1:0] sw = 2'b00;
  logic open_b, err_b, open_h, err_h;
  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  code_lock_top #(.ONE_HOT(1'b0)) dut_i (
    .clk(clk), .rst(rst), .enter_i(enter), .sw_i(sw), .open_o(open_b), .error_o(err_b)
  );
  code_lock_top #(.ONE_HOT(1'b1)) dut_oh_i (
    .clk(clk), .rst(rst), .enter_i(enter), .sw_i(sw), .open_o(open_h), .error_o(err_h)
  );

  // R9: both encodings compared on every falling edge
  always @(negedge clk) begin
    if (!finished) begin
      n_checks++;
      if ({open_b, err_b} !== {open_h, err_h}) begin
        n_fail++;
        $display("FAIL R9 encodings differ: binary=%b%b onehot=%b%b expected equal",
                 open_b, err_b, open_h, err_h);
      end
    end
  end

  task automatic check(input string tag, input logic exp_open, input logic exp_err);
    n_checks++;
    if (open_b !== exp_open || err_b !== exp_err) begin
      n_fail++;
      $display("FAIL %s: open/error=%b%b expected %b%b", tag, open_b, err_b, exp_open, exp_err);
    end
    n_checks++;
    if (open_b && err_b) begin
      n_fail++;
      $display("FAIL R10 (%s): open/error=%b%b expected not both set", tag, open_b, err_b);
    end
  endtask

  // called at a falling edge; one rising edge passes with the given inputs
  task automatic tick(input logic e, input logic [1:0] s);
    enter = e;
    sw = s;
    @(negedge clk);
    enter = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick(1'b0, 2'b00);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    rst = 1'b1;
    tick(1'b0, 2'b00);
    check("R1 during reset", 1'b0, 1'b0);
    rst = 1'b0;
    tick(1'b0, 2'b00);
    check("R1 after release", 1'b0, 1'b0);
  endtask

  task automatic t_correct_code();
    do_reset();
    tick(1'b1, 2'b01);
    check("R2 first word accepted", 1'b0, 1'b0);
    tick(1'b0, 2'b11);
    tick(1'b0, 2'b10);
    tick(1'b0, 2'b00);
    check("R3 idle cycles with switch changes", 1'b0, 1'b0);
    tick(1'b1, 2'b11);
    check("R4 second word opens", 1'b1, 1'b0);
    tick(1'b1, 2'b00);
    tick(1'b1, 2'b01);
    tick(1'b0, 2'b10);
    check("R7 open held", 1'b1, 1'b0);
  endtask

  task automatic t_wrong_first();
    do_reset();
    tick(1'b1, 2'b10);
    check("R5 wrong first silent", 1'b0, 1'b0);
    tick(1'b0, 2'b01);
    check("R3 idle after wrong first", 1'b0, 1'b0);
    tick(1'b1, 2'b11);
    check("R5 error after second entry", 1'b0, 1'b1);
    tick(1'b1, 2'b01);
    tick(1'b1, 2'b11);
    check("R7 error held", 1'b0, 1'b1);
  endtask

  task automatic t_wrong_second();
    do_reset();
    tick(1'b1, 2'b01);
    tick(1'b1, 2'b01);
    check("R6 wrong second word", 1'b0, 1'b1);
  endtask

  task automatic t_idle_switch_ignored();
    // a WORD_B pattern on the switches while the strobe is low must not count
    do_reset();
    tick(1'b1, 2'b01);
    tick(1'b0, 2'b11);
    check("R3 switch without strobe", 1'b0, 1'b0);
    tick(1'b1, 2'b00);
    check("R3 later entry still judged", 1'b0, 1'b1);
  endtask

  task automatic t_mid_reset();
    do_reset();
    tick(1'b1, 2'b01);
    rst = 1'b1;
    tick(1'b1, 2'b11);
    rst = 1'b0;
    check("R8 reset beats strobe", 1'b0, 1'b0);
    tick(1'b1, 2'b01);
    tick(1'b1, 2'b11);
    check("R8 fresh sequence after reset", 1'b1, 1'b0);
    do_reset();
    check("R8 reset from unlocked", 1'b0, 1'b0);
    tick(1'b1, 2'b00);
    tick(1'b1, 2'b00);
    check("R8 reach alarm", 1'b0, 1'b1);
    do_reset();
    check("R8 reset from alarm", 1'b0, 1'b0);
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset_state();
    t_correct_code();
    t_wrong_first();
    t_wrong_second();
    t_idle_switch_ignored();
    t_mid_reset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule